// File: doc/BRIEF.md
# Set-Associative Translation Buffer with Address-Space Tags

This block caches virtual-to-physical page translations for a 14-bit virtual address space with 64-byte pages. It holds 16 translations as 4 sets of 4 ways. Every entry is tagged with an address-space identifier, so several processes can keep their translations resident at once without clearing the buffer on each context switch. Each entry also carries read, write and execute permissions and a dirty flag.

A lookup request (virtual address, current identifier, access kind) is captured on a clock edge. In the cycle that follows, the block reports exactly one of hit, miss or protection fault. On a hit it also gives the 12-bit physical address and the entry's dirty flag. A miss is only reported; finding the missing translation is left to the surrounding logic, which then installs it through the fill port. A flush input clears every entry at once.

Top module: `tlbx_top`

## Requirements
- R1: Virtual address bits 5:0 are the page offset, bits 7:6 select the set and bits 13:8 are the tag. On a hit the physical address is the entry's 6-bit page number in bits 11:6, joined with the unchanged offset in bits 5:0.
- R2: A request sampled at a clock edge (req_valid_i high) is answered in the cycle after that edge with rsp_valid_o high. When no request is sampled, rsp_valid_o is low. A fill or flush taken at the same edge already affects that answer.
- R3: A hit needs an entry in the selected set that is valid and whose tag and identifier both equal the request's. While rsp_valid_o is high, exactly one of rsp_hit_o, rsp_miss_o and rsp_fault_o is high. While it is low, all three are low.
- R4: The same virtual page installed under two different identifiers gives two independent entries, and each identifier translates to its own page number.
- R5: The access kind is encoded 0 = read, 1 = write, 2 = fetch, 3 = read. The permission field encodes bit 0 = read, bit 1 = write, bit 2 = execute. A matching entry that lacks the permission needed by the access gives rsp_fault_o instead of a hit.
- R6: On a hit, rsp_paddr_o and rsp_dirty_o come from the matching entry. On a miss or a fault, both are zero.
- R7: A fill goes into the lowest-numbered invalid way of its set.
- R8: When all ways of the set are valid, a fill replaces the way named by that set's 2-bit rotating pointer. Each set's pointer starts at 0 after reset or flush and advances by one only on a fill that replaces an entry.
- R9: Flush invalidates every entry and returns every pointer to 0. A fill that arrives at the same edge as a flush is dropped.
- R10: After reset, every entry is invalid and rsp_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Lookup request strobe |
| req_vaddr_i | input | 14 | Virtual address to translate |
| req_asid_i | input | 4 | Current address-space identifier |
| req_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| fill_valid_i | input | 1 | Install a translation |
| fill_vpn_i | input | 8 | Virtual page number of the new translation |
| fill_asid_i | input | 4 | Identifier of the new translation |
| fill_ppn_i | input | 6 | Physical page number of the new translation |
| fill_perm_i | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| fill_dirty_i | input | 1 | Dirty flag of the new translation |
| flush_i | input | 1 | Invalidate all entries |
| rsp_valid_o | output | 1 | Response present this cycle |
| rsp_hit_o | output | 1 | Translation found and permitted |
| rsp_miss_o | output | 1 | No matching entry |
| rsp_fault_o | output | 1 | Matching entry lacks the needed permission |
| rsp_paddr_o | output | 12 | Physical address on a hit, else zero |
| rsp_dirty_o | output | 1 | Dirty flag of the hit entry, else zero |

## Verification
The assertions check on every cycle that the response is one-hot while valid and silent while idle, that it appears one cycle after a request, that the offset passes through on a hit, and that the address and dirty outputs stay zero when there is no hit. They also check that a flush leaves no valid entry, that the rotating pointers move only on replacing fills, and that a free way is always chosen while one exists. Whether the right way is evicted, whether identifiers keep processes apart, and whether permissions are judged correctly can only be shown by the bench scenarios. The bench fills sets past capacity and then sweeps every page, identifier and access kind against its own model.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_ALT   = 2'd3
  } acc_e;

  localparam int PERM_W = 3;
  localparam int PERM_R = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_X = 2;

endpackage

// File: rtl/tlbx_way_store.sv
module tlbx_way_store #(
  parameter int SETS   = 4,
  parameter int TAG_W  = 6,
  parameter int ASID_W = 4,
  parameter int PPN_W  = 6,
  localparam int SET_W = $clog2(SETS),
  localparam int PAY_W = TAG_W + ASID_W + PPN_W + tlbx_pkg::PERM_W + 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        flush_i,
  input  logic                        wr_en_i,
  input  logic [SET_W-1:0]            wr_set_i,
  input  logic [TAG_W-1:0]            wr_tag_i,
  input  logic [ASID_W-1:0]           wr_asid_i,
  input  logic [PPN_W-1:0]            wr_ppn_i,
  input  logic [tlbx_pkg::PERM_W-1:0] wr_perm_i,
  input  logic                        wr_dirty_i,
  input  logic [SET_W-1:0]            rd_set_i,
  output logic                        rd_valid_o,
  output logic [TAG_W-1:0]            rd_tag_o,
  output logic [ASID_W-1:0]           rd_asid_o,
  output logic [PPN_W-1:0]            rd_ppn_o,
  output logic [tlbx_pkg::PERM_W-1:0] rd_perm_o,
  output logic                        rd_dirty_o,
  output logic [SETS-1:0]             valid_vec_o
);

  // Payload kept in a reset-free array so it maps to distributed RAM.
  logic [PAY_W-1:0] mem_q [SETS];
  logic [SETS-1:0]  valid_q;

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      mem_q[wr_set_i] <= {wr_tag_i, wr_asid_i, wr_ppn_i, wr_perm_i, wr_dirty_i};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush_i) begin
      valid_q <= '0;
    end else if (wr_en_i) begin
      valid_q[wr_set_i] <= 1'b1;
    end
  end

  assign {rd_tag_o, rd_asid_o, rd_ppn_o, rd_perm_o, rd_dirty_o} = mem_q[rd_set_i];
  assign rd_valid_o  = valid_q[rd_set_i];
  assign valid_vec_o = valid_q;

  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> (valid_vec_o == '0));

  // R2
  fill_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !flush_i) |=> valid_q[$past(wr_set_i)]);

endmodule

// File: rtl/tlbx_victim.sv
module tlbx_victim #(
  parameter int SETS = 4,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush_i,
  input  logic             fill_i,
  input  logic [SET_W-1:0] set_i,
  input  logic [WAYS-1:0]  valid_i,
  output logic [WAY_W-1:0] way_o
);

  logic [SETS*WAY_W-1:0] rr_q;
  logic [WAY_W-1:0]      rr_sel;
  logic                  set_full;

  assign rr_sel   = rr_q[int'(set_i)*WAY_W +: WAY_W];
  assign set_full = &valid_i;

  always_comb begin
    logic found;
    found = 1'b0;
    way_o = rr_sel;
    for (int w = 0; w < WAYS; w++) begin
      if (!valid_i[w] && !found) begin
        way_o = WAY_W'(w);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush_i) begin
      rr_q <= '0;
    end else if (fill_i && set_full) begin
      rr_q[int'(set_i)*WAY_W +: WAY_W] <= rr_sel + 1'b1;
    end
  end

  // R7
  free_way_first_chk: assert property (@(posedge clk) disable iff (rst)
    !set_full |-> !valid_i[way_o]);

  // R8
  pointer_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!flush_i && !(fill_i && set_full)) |=> $stable(rr_q));

endmodule

// File: rtl/tlbx_top.sv
module tlbx_top #(
  parameter int VA_W   = 14,
  parameter int OFF_W  = 6,
  parameter int PPN_W  = 6,
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  parameter int ASID_W = 4,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int SET_W = $clog2(SETS),
  localparam int TAG_W = VPN_W - SET_W,
  localparam int WAY_W = $clog2(WAYS),
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid_i,
  input  logic [VA_W-1:0]             req_vaddr_i,
  input  logic [ASID_W-1:0]           req_asid_i,
  input  logic [1:0]                  req_acc_i,
  input  logic                        fill_valid_i,
  input  logic [VPN_W-1:0]            fill_vpn_i,
  input  logic [ASID_W-1:0]           fill_asid_i,
  input  logic [PPN_W-1:0]            fill_ppn_i,
  input  logic [tlbx_pkg::PERM_W-1:0] fill_perm_i,
  input  logic                        fill_dirty_i,
  input  logic                        flush_i,
  output logic                        rsp_valid_o,
  output logic                        rsp_hit_o,
  output logic                        rsp_miss_o,
  output logic                        rsp_fault_o,
  output logic [PA_W-1:0]             rsp_paddr_o,
  output logic                        rsp_dirty_o
);
  import tlbx_pkg::*;

  // Registered request
  logic              req_v_q;
  logic [VA_W-1:0]   req_va_q;
  logic [ASID_W-1:0] req_asid_q;
  acc_e              req_acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_v_q    <= 1'b0;
      req_va_q   <= '0;
      req_asid_q <= '0;
      req_acc_q  <= ACC_LOAD;
    end else begin
      req_v_q <= req_valid_i;
      if (req_valid_i) begin
        req_va_q   <= req_vaddr_i;
        req_asid_q <= req_asid_i;
        req_acc_q  <= acc_e'(req_acc_i);
      end
    end
  end

  logic [SET_W-1:0] look_set;
  logic [TAG_W-1:0] look_tag;
  assign look_set = req_va_q[OFF_W +: SET_W];
  assign look_tag = req_va_q[VA_W-1 -: TAG_W];

  // Fill side
  logic [SET_W-1:0] fill_set;
  logic [TAG_W-1:0] fill_tag;
  logic [WAY_W-1:0] victim_way;
  logic             fill_go;
  assign fill_set = fill_vpn_i[SET_W-1:0];
  assign fill_tag = fill_vpn_i[VPN_W-1 -: TAG_W];
  assign fill_go  = fill_valid_i && !flush_i;

  logic [SETS-1:0]       way_valid_vec [WAYS];
  logic [WAYS-1:0]       fill_set_valid;
  logic [WAYS-1:0]       rd_valid;
  logic [TAG_W-1:0]      rd_tag   [WAYS];
  logic [ASID_W-1:0]     rd_asid  [WAYS];
  logic [PPN_W-1:0]      rd_ppn   [WAYS];
  logic [PERM_W-1:0]     rd_perm  [WAYS];
  logic [WAYS-1:0]       rd_dirty;
  logic [WAYS-1:0]       way_match;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    tlbx_way_store #(
      .SETS(SETS), .TAG_W(TAG_W), .ASID_W(ASID_W), .PPN_W(PPN_W)
    ) store_i (
      .clk        (clk),
      .rst        (rst),
      .flush_i    (flush_i),
      .wr_en_i    (fill_go && (victim_way == WAY_W'(w))),
      .wr_set_i   (fill_set),
      .wr_tag_i   (fill_tag),
      .wr_asid_i  (fill_asid_i),
      .wr_ppn_i   (fill_ppn_i),
      .wr_perm_i  (fill_perm_i),
      .wr_dirty_i (fill_dirty_i),
      .rd_set_i   (look_set),
      .rd_valid_o (rd_valid[w]),
      .rd_tag_o   (rd_tag[w]),
      .rd_asid_o  (rd_asid[w]),
      .rd_ppn_o   (rd_ppn[w]),
      .rd_perm_o  (rd_perm[w]),
      .rd_dirty_o (rd_dirty[w]),
      .valid_vec_o(way_valid_vec[w])
    );
    assign fill_set_valid[w] = way_valid_vec[w][fill_set];
    assign way_match[w] = rd_valid[w] && (rd_tag[w] == look_tag)
                          && (rd_asid[w] == req_asid_q);
  end

  tlbx_victim #(.SETS(SETS), .WAYS(WAYS)) victim_i (
    .clk     (clk),
    .rst     (rst),
    .flush_i (flush_i),
    .fill_i  (fill_go),
    .set_i   (fill_set),
    .valid_i (fill_set_valid),
    .way_o   (victim_way)
  );

  // Way selection (OR-mux over at most one match)
  logic              any_match;
  logic [PPN_W-1:0]  sel_ppn;
  logic [PERM_W-1:0] sel_perm;
  logic              sel_dirty;

  always_comb begin
    any_match = 1'b0;
    sel_ppn   = '0;
    sel_perm  = '0;
    sel_dirty = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_match[w]) begin
        any_match = 1'b1;
        sel_ppn   = sel_ppn | rd_ppn[w];
        sel_perm  = sel_perm | rd_perm[w];
        sel_dirty = sel_dirty | rd_dirty[w];
      end
    end
  end

  logic allowed;
  always_comb begin
    case (req_acc_q)
      ACC_STORE: allowed = sel_perm[PERM_WR];
      ACC_FETCH: allowed = sel_perm[PERM_X];
      default:   allowed = sel_perm[PERM_R];
    endcase
  end

  assign rsp_valid_o = req_v_q;
  assign rsp_hit_o   = req_v_q && any_match && allowed;
  assign rsp_fault_o = req_v_q && any_match && !allowed;
  assign rsp_miss_o  = req_v_q && !any_match;
  assign rsp_paddr_o = rsp_hit_o ? {sel_ppn, req_va_q[OFF_W-1:0]} : '0;
  assign rsp_dirty_o = rsp_hit_o && sel_dirty;

  // R3
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_o |-> ($countones({rsp_hit_o, rsp_miss_o, rsp_fault_o}) == 1));

  // R3
  idle_silent_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid_o |-> ({rsp_hit_o, rsp_miss_o, rsp_fault_o} == 3'b000));

  // R2
  resp_timing_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rsp_valid_o == $past(req_valid_i)));

  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && rsp_hit_o) |-> (rsp_paddr_o[OFF_W-1:0] == $past(req_vaddr_i[OFF_W-1:0])));

  // R6
  no_hit_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit_o |-> (rsp_paddr_o == '0 && !rsp_dirty_o));

endmodule

// File: tb/tlbx_top_tb_top.sv
module tlbx_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid_i = 1'b0;
  logic [13:0] req_vaddr_i = '0;
  logic [3:0]  req_asid_i = '0;
  logic [1:0]  req_acc_i = '0;
  logic        fill_valid_i = 1'b0;
  logic [7:0]  fill_vpn_i = '0;
  logic [3:0]  fill_asid_i = '0;
  logic [5:0]  fill_ppn_i = '0;
  logic [2:0]  fill_perm_i = '0;
  logic        fill_dirty_i = 1'b0;
  logic        flush_i = 1'b0;
  logic        rsp_valid_o, rsp_hit_o, rsp_miss_o, rsp_fault_o, rsp_dirty_o;
  logic [11:0] rsp_paddr_o;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlbx_top dut_i (
    .clk, .rst, .req_valid_i, .req_vaddr_i, .req_asid_i, .req_acc_i,
    .fill_valid_i, .fill_vpn_i, .fill_asid_i, .fill_ppn_i, .fill_perm_i,
    .fill_dirty_i, .flush_i, .rsp_valid_o, .rsp_hit_o, .rsp_miss_o,
    .rsp_fault_o, .rsp_paddr_o, .rsp_dirty_o
  );

  // Reference model
  bit         m_valid [4][4];
  logic [5:0] m_tag   [4][4];
  logic [3:0] m_asid  [4][4];
  logic [5:0] m_ppn   [4][4];
  logic [2:0] m_perm  [4][4];
  bit         m_dirty [4][4];
  int         m_rr    [4];

  function automatic void model_clear();
    for (int s = 0; s < 4; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < 4; w++) m_valid[s][w] = 0;
    end
  endfunction

  function automatic void model_fill(logic [7:0] vpn, logic [3:0] asid,
                                     logic [5:0] ppn, logic [2:0] perm, bit dirty);
    int s;
    int way;
    s = int'(vpn[1:0]);
    way = -1;
    for (int w = 0; w < 4; w++) if (!m_valid[s][w] && way < 0) way = w;
    if (way < 0) begin
      way = m_rr[s];
      m_rr[s] = (m_rr[s] + 1) % 4;
    end
    m_valid[s][way] = 1;
    m_tag[s][way]   = vpn[7:2];
    m_asid[s][way]  = asid;
    m_ppn[s][way]   = ppn;
    m_perm[s][way]  = perm;
    m_dirty[s][way] = dirty;
  endfunction

  function automatic logic [16:0] model_look(logic [13:0] va, logic [3:0] asid, logic [1:0] acc);
    int s;
    logic [2:0] need;
    s = int'(va[7:6]);
    need = (acc == 2'd1) ? 3'b010 : (acc == 2'd2) ? 3'b100 : 3'b001;
    for (int w = 0; w < 4; w++) begin
      if (m_valid[s][w] && m_tag[s][w] == va[13:8] && m_asid[s][w] == asid) begin
        if ((m_perm[s][w] & need) != 0)
          return {1'b1, 3'b100, m_dirty[s][w], m_ppn[s][w], va[5:0]};
        return {1'b1, 3'b001, 1'b0, 12'h000};
      end
    end
    return {1'b1, 3'b010, 1'b0, 12'h000};
  endfunction

  function automatic logic [16:0] dut_vec();
    return {rsp_valid_o, rsp_hit_o, rsp_miss_o, rsp_fault_o, rsp_dirty_o, rsp_paddr_o};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(logic [16:0] e);
    if (e[14]) return "R3";
    if (e[13]) return "R5";
    return "R6";
  endfunction

  // All tasks start and end at a falling edge.
  task automatic do_fill(logic [7:0] vpn, logic [3:0] asid, logic [5:0] ppn,
                         logic [2:0] perm, bit dirty);
    fill_valid_i = 1; fill_vpn_i = vpn; fill_asid_i = asid;
    fill_ppn_i = ppn; fill_perm_i = perm; fill_dirty_i = dirty;
    @(posedge clk);
    model_fill(vpn, asid, ppn, perm, dirty);
    @(negedge clk);
    fill_valid_i = 0;
  endtask

  task automatic do_flush();
    flush_i = 1;
    @(posedge clk);
    model_clear();
    @(negedge clk);
    flush_i = 0;
  endtask

  task automatic do_look(logic [13:0] va, logic [3:0] asid, logic [1:0] acc, string req);
    logic [16:0] e;
    req_valid_i = 1; req_vaddr_i = va; req_asid_i = asid; req_acc_i = acc;
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 0;
    e = model_look(va, asid, acc);
    check(dut_vec() == e, (req == "") ? tag_of(e) : req, 32'(dut_vec()), 32'(e));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst = 0;
    // R10: idle after reset
    check(rsp_valid_o == 0, "R10", 32'(rsp_valid_o), 0);
    // R10: nothing valid after reset, every page misses
    for (int v = 0; v < 256; v++) do_look({v[7:0], 6'h2A}, 4'd0, 2'd0, "R10");
    // R2: idle cycle gives no response
    @(negedge clk);
    check(dut_vec() == '0, "R2", 32'(dut_vec()), 0);

    // R1: page 0x0F, set 3, tag 0x03 -> paddr 0x354
    do_fill(8'h0F, 4'd1, 6'h0D, 3'b111, 1'b0);
    do_look(14'h03D4, 4'd1, 2'd0, "R1");
    check(rsp_paddr_o == 12'h354, "R1", 32'(rsp_paddr_o), 32'h354);
    // R3: identifier mismatch misses
    do_look(14'h03D4, 4'd2, 2'd0, "R3");
    check(rsp_miss_o == 1, "R3", 32'(rsp_miss_o), 1);
    // R4: second identifier, same page, other frame
    do_fill(8'h0F, 4'd2, 6'h2D, 3'b001, 1'b1);
    do_look(14'h03D4, 4'd2, 2'd0, "R4");
    check(rsp_paddr_o == 12'hB54, "R4", 32'(rsp_paddr_o), 32'hB54);
    do_look(14'h03C0, 4'd1, 2'd0, "R4");
    check(rsp_paddr_o == 12'h340, "R4", 32'(rsp_paddr_o), 32'h340);
    // R5: write to read-only entry faults
    do_look(14'h03D4, 4'd2, 2'd1, "R5");
    check(rsp_fault_o == 1, "R5", 32'(rsp_fault_o), 1);
    // R6: dirty flag reported on hit
    do_look(14'h03D4, 4'd2, 2'd3, "R6");
    check(rsp_dirty_o == 1, "R6", 32'(rsp_dirty_o), 1);

    // R2: request in same cycle as fill sees it
    fill_valid_i = 1; fill_vpn_i = 8'h21; fill_asid_i = 4'd5;
    fill_ppn_i = 6'h11; fill_perm_i = 3'b001; fill_dirty_i = 0;
    req_valid_i = 1; req_vaddr_i = 14'h0845; req_asid_i = 4'd5; req_acc_i = 2'd0;
    @(posedge clk);
    model_fill(8'h21, 4'd5, 6'h11, 3'b001, 1'b0);
    @(negedge clk);
    fill_valid_i = 0; req_valid_i = 0;
    check(rsp_hit_o && rsp_paddr_o == 12'h445, "R2", 32'(rsp_paddr_o), 32'h445);

    // R9: flush with simultaneous fill drops the fill
    flush_i = 1; fill_valid_i = 1; fill_vpn_i = 8'h33; fill_asid_i = 4'd0;
    fill_ppn_i = 6'h01; fill_perm_i = 3'b111;
    @(posedge clk);
    model_clear();
    @(negedge clk);
    flush_i = 0; fill_valid_i = 0;
    do_look(14'h0CC0, 4'd0, 2'd0, "R9");
    check(rsp_miss_o == 1, "R9", 32'(rsp_miss_o), 1);
    do_look(14'h03D4, 4'd1, 2'd0, "R9");

    // R7 R8: six fills per set, two replacements each
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 6; k++) begin
        logic [5:0] tg;
        tg = 6'((s * 9 + k * 5 + 1) % 64);
        do_fill({tg, s[1:0]}, 4'(k % 3), 6'((s * 16 + k * 7) % 64),
                3'(k + s), k[0]);
      end
    end
    // R8: way 0 of each set evicted first, way 1 second
    for (int s = 0; s < 4; s++) begin
      logic [5:0] t0;
      logic [5:0] t2;
      t0 = 6'((s * 9 + 1) % 64);
      t2 = 6'((s * 9 + 11) % 64);
      do_look({t0, s[1:0], 6'h00}, 4'd0, 2'd0, "R8");
      check(rsp_miss_o == 1, "R8", 32'(rsp_miss_o), 1);
      do_look({t2, s[1:0], 6'h00}, 4'd2, 2'd3, "R7");
    end
    // Sweep: all pages x identifiers x access kinds
    for (int v = 0; v < 256; v++)
      for (int a = 0; a < 3; a++)
        for (int c = 0; c < 4; c++)
          do_look({v[7:0], v[5:0] ^ 6'h15}, 4'(a), 2'(c), "");

    // R9: flush clears everything and rewinds pointers
    do_flush();
    for (int v = 0; v < 256; v++) do_look({v[7:0], 6'h00}, 4'(v % 3), 2'd0, "R9");
    for (int k = 0; k < 5; k++) do_fill({6'(k + 40), 2'd1}, 4'd3, 6'(k + 1), 3'b111, 1'b0);
    for (int k = 0; k < 5; k++) do_look({6'(k + 40), 2'd1, 6'h3F}, 4'd3, 2'd2, "R8");

    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule